// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is an eight-line general-purpose I/O port controller attached to a small register bus. Software programs per-line drive value, drive enable, pull resistor control and a two-bit function selector that hands the line to either of two peripherals. The controller drives the pad's output value, output enable and pull controls, and hands the synchronised pin levels back to the peripherals.

Each line's level passes through a two-flop synchroniser. A change of the synchronised level of the polarity chosen for that line latches a sticky pending flag. Software can also set the flag, and only software clears it. The pending flags, masked by the per-line enables and by a single global-enable input, are combined into one interrupt request.

Because the observed level includes the port's own drive, a write to the drive value or to the drive enable that changes a line's level raises its flag in the same way an external change does.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every writable register reads 0, `pad_oe`, `pull_up`, `pull_dn` and `irq` are 0, and no flag becomes set while the pins stay low.
- R2: `pad_oe[i]` equals the drive-enable bit of register 4'h2, whatever the function code of the line.
- R3: Address 4'h0 is read-only and returns the pin levels as sampled two clock edges earlier.
- R4: When bit i of the pull register 4'h3 is 1, bit i of the drive register 4'h1 selects the pull direction: `pull_up[i]` for 1, `pull_dn[i]` for 0. When the pull bit is 0, both are 0.
- R5: The function code of line i is {bit i of 4'h5, bit i of 4'h4}. 2'b00 drives `pad_out[i]` from register 4'h1, 2'b01 from `prim_out[i]`, 2'b11 from `sec_out[i]`, and the reserved code 2'b10 drives 0.
- R6: Bit i of the polarity register 4'h7 selects the edge that sets flag i: 0 for low-to-high and 1 for high-to-low. An edge of the other polarity leaves the flag alone.
- R7: The flag register 4'h8 is sticky. A written 1 sets a flag, a written 0 clears it, and a flag otherwise keeps its value.
- R8: When a qualifying edge and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when `gie` is 1 and some line has both its flag and its enable bit (register 4'h6) set.
- R10: No edge sets the flag of a line whose function code is not 2'b00.
- R11: A write to register 4'h1 or 4'h2 that changes a driven line's level sets that line's flag when the change has the selected polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Value driven to each pad |
| pad_oe | output | 8 | Drive enable per pad |
| pull_up | output | 8 | Pull-up request per pad |
| pull_dn | output | 8 | Pull-down request per pad |
| prim_out | input | 8 | Primary peripheral output values |
| sec_out | input | 8 | Secondary peripheral output values |
| periph_in | output | 8 | Synchronised pin levels to the peripherals |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Edge detection is swept over every line and both polarities, with both rising and falling stimulus. This shows that the polarity bit, not the edge alone, decides whether a flag is set, and that only the targeted bit moves. The same rising stimulus on all lines is repeated under each of the four function codes, which separates GPIO lines from lines handed to a peripheral. The interrupt combine is swept over all 256 enable masks against a fixed flag pattern with the global enable both on and off, and the pull outputs are swept over all 256 pull masks against two drive patterns. Loopback writes to the drive value and drive enable, together with an edge that collides with a software clear, cover the cases that only arise from how the port's own registers interact.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [3:0] {
        RA_LEVEL  = 4'h0,
        RA_DRIVE  = 4'h1,
        RA_OE     = 4'h2,
        RA_PULL   = 4'h3,
        RA_FSEL0  = 4'h4,
        RA_FSEL1  = 4'h5,
        RA_IEN    = 4'h6,
        RA_POL    = 4'h7,
        RA_FLAG   = 4'h8
    } gpio_reg_e;

    typedef enum logic [1:0] {
        PM_GPIO = 2'b00,
        PM_PRIM = 2'b01,
        PM_RSVD = 2'b10,
        PM_SEC  = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int ARM = 3;

    logic [W-1:0]   meta_q, lvl_q, prev_q;
    logic [ARM-1:0] arm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
            arm_q  <= '0;
        end else begin
            meta_q <= pad_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
            arm_q  <= {arm_q[ARM-2:0], 1'b1};
        end
    end

    assign level_o = lvl_q;
    assign rise_o  = arm_q[ARM-1] ? (lvl_q & ~prev_q) : '0;
    assign fall_o  = arm_q[ARM-1] ? (~lvl_q & prev_q) : '0;

    // R3: the visible level is the pin value from two edges back
    a_r3_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q[ARM-1] |-> (level_o == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] fsel0,
    input  logic [W-1:0] fsel1,
    input  logic [W-1:0] drive,
    input  logic [W-1:0] prim_out,
    input  logic [W-1:0] sec_out,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] periph_mask
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_mode_e mode;
        logic      val;
        logic      is_periph;

        assign mode = pin_mode_e'({fsel1[i], fsel0[i]});

        always_comb begin
            unique case (mode)
                PM_GPIO: begin val = drive[i];    is_periph = 1'b0; end
                PM_PRIM: begin val = prim_out[i]; is_periph = 1'b1; end
                PM_SEC:  begin val = sec_out[i];  is_periph = 1'b1; end
                PM_RSVD: begin val = 1'b0;        is_periph = 1'b1; end
                default: begin val = 1'b0;        is_periph = 1'b1; end
            endcase
        end

        assign pad_out[i]     = val;
        assign periph_mask[i] = is_periph;
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] periph_mask,
    input  logic [W-1:0] ien,
    input  logic         gie,
    input  logic         flag_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags_o,
    output logic         irq_o
);
    logic [W-1:0] flag_q, hit, base;

    assign hit  = ((rise & ~pol) | (fall & pol)) & ~periph_mask;
    assign base = flag_wr ? wdata : flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= base | hit;
    end

    assign flags_o = flag_q;
    assign irq_o   = gie & (|(flag_q & ien));

    // R7: without a write, no pending flag is lost
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
    // R10: a peripheral-owned line never gains a flag except by software
    a_r10_periph_block: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag_q & ~$past(flag_q) & $past(periph_mask)) == '0));
    // R9: the request is silent while the global enable is low
    a_r9_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_o);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pull_up,
    output logic [W-1:0] pull_dn,
    input  logic [W-1:0] prim_out,
    input  logic [W-1:0] sec_out,
    output logic [W-1:0] periph_in,
    input  logic         gie,
    output logic         irq
);
    gpio_reg_e    addr;
    logic [W-1:0] drive_q, oe_q, pull_q, fsel0_q, fsel1_q, ien_q, pol_q;
    logic [W-1:0] level, rise, fall, flags, periph_mask;
    logic         flag_wr;

    assign addr    = gpio_reg_e'(bus_addr);
    assign flag_wr = bus_we && (addr == RA_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
            oe_q    <= '0;
            pull_q  <= '0;
            fsel0_q <= '0;
            fsel1_q <= '0;
            ien_q   <= '0;
            pol_q   <= '0;
        end else if (bus_we) begin
            case (addr)
                RA_DRIVE: drive_q <= bus_wdata;
                RA_OE:    oe_q    <= bus_wdata;
                RA_PULL:  pull_q  <= bus_wdata;
                RA_FSEL0: fsel0_q <= bus_wdata;
                RA_FSEL1: fsel1_q <= bus_wdata;
                RA_IEN:   ien_q   <= bus_wdata;
                RA_POL:   pol_q   <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            RA_LEVEL: bus_rdata = level;
            RA_DRIVE: bus_rdata = drive_q;
            RA_OE:    bus_rdata = oe_q;
            RA_PULL:  bus_rdata = pull_q;
            RA_FSEL0: bus_rdata = fsel0_q;
            RA_FSEL1: bus_rdata = fsel1_q;
            RA_IEN:   bus_rdata = ien_q;
            RA_POL:   bus_rdata = pol_q;
            RA_FLAG:  bus_rdata = flags;
            default:  bus_rdata = '0;
        endcase
    end

    gpio_in_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    gpio_pin_mux #(.W(W)) u_mux (
        .fsel0(fsel0_q), .fsel1(fsel1_q), .drive(drive_q),
        .prim_out(prim_out), .sec_out(sec_out),
        .pad_out(pad_out), .periph_mask(periph_mask)
    );

    gpio_irq #(.W(W)) u_irq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .pol(pol_q), .periph_mask(periph_mask), .ien(ien_q), .gie(gie),
        .flag_wr(flag_wr), .wdata(bus_wdata),
        .flags_o(flags), .irq_o(irq)
    );

    assign pad_oe    = oe_q;
    assign pull_up   = pull_q & drive_q;
    assign pull_dn   = pull_q & ~drive_q;
    assign periph_in = level;

    // R4: a pad is never pulled both ways at once
    a_r4_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & pull_dn) == '0);
    // R2: the drive enable follows the last write to its register
    a_r2_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && addr == RA_OE) |=> (pad_oe == $past(bus_wdata)));
endmodule

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in, pad_out, pad_oe, pull_up, pull_dn, periph_in;
    logic [7:0] prim_out = 8'h5A;
    logic [7:0] sec_out  = 8'hC3;
    logic [7:0] ext = '0;
    logic       gie = 1'b0;
    logic       irq;
    int         total = 0;
    int         bad = 0;

    always #5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_edge_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn),
        .prim_out(prim_out), .sec_out(sec_out), .periph_in(periph_in),
        .gie(gie), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        #1500000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        tick(2);
        rst_n = 1'b1;
        tick(6);
        // R1 reset state
        for (int a = 1; a <= 8; a++) begin
            rd(4'(a), v);
            chk("R1 reg", v, 8'h00);
        end
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pulls", pull_up | pull_dn, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R3 level register and read-only
        for (int k = 0; k < 4; k++) begin
            ext = 8'(8'h3C << k) ^ 8'(k * 37);
            tick(3);
            rd(4'h0, v);
            chk("R3 level", v, ext);
        end
        wr(4'h0, 8'hFF);
        rd(4'h0, v);
        chk("R3 read-only", v, ext);
        ext = 8'h00;
        tick(4);
        wr(4'h8, 8'h00);

        // R4 pull sweep
        for (int o = 0; o < 2; o++) begin
            wr(4'h1, o == 0 ? 8'h0F : 8'h3C);
            for (int p = 0; p < 256; p++) begin
                wr(4'h3, 8'(p));
                chk("R4 up", pull_up, 8'(p) & (o == 0 ? 8'h0F : 8'h3C));
                chk("R4 dn", pull_dn, 8'(p) & ~(o == 0 ? 8'h0F : 8'h3C));
            end
        end
        wr(4'h3, 8'h00);

        // R5 / R2 mux and drive enable per mode
        wr(4'h1, 8'h96);
        for (int m = 0; m < 4; m++) begin
            wr(4'h4, m[0] ? 8'hFF : 8'h00);
            wr(4'h5, m[1] ? 8'hFF : 8'h00);
            v = (m == 0) ? 8'h96 : (m == 1) ? 8'h5A : (m == 3) ? 8'hC3 : 8'h00;
            chk("R5 mux", pad_out, v);
            wr(4'h2, 8'hA5);
            chk("R2 oe", pad_oe, 8'hA5);
            wr(4'h2, 8'h00);
        end
        wr(4'h4, 8'h00); wr(4'h5, 8'h00); wr(4'h1, 8'h00);
        tick(4);
        wr(4'h8, 8'h00);

        // R6 edge polarity sweep
        for (int p = 0; p < 8; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                wr(4'h7, pol ? 8'(1 << p) : 8'h00);
                ext[p] = 1'b1; tick(4);
                rd(4'h8, v);
                chk("R6 rise", v, pol ? 8'h00 : 8'(1 << p));
                wr(4'h8, 8'h00);
                ext[p] = 1'b0; tick(4);
                rd(4'h8, v);
                chk("R6 fall", v, pol ? 8'(1 << p) : 8'h00);
                wr(4'h8, 8'h00);
            end
        end
        wr(4'h7, 8'h00);

        // R10 no flags on peripheral lines
        for (int m = 0; m < 4; m++) begin
            wr(4'h4, m[0] ? 8'hFF : 8'h00);
            wr(4'h5, m[1] ? 8'hFF : 8'h00);
            ext = 8'hFF; tick(4);
            rd(4'h8, v);
            chk("R10 mode", v, m == 0 ? 8'hFF : 8'h00);
            ext = 8'h00; tick(4);
            wr(4'h8, 8'h00);
        end
        wr(4'h4, 8'h00); wr(4'h5, 8'h00);

        // R7 sticky and software set/clear
        wr(4'h8, 8'h3C);
        tick(10);
        rd(4'h8, v);
        chk("R7 hold", v, 8'h3C);
        wr(4'h8, 8'h24);
        rd(4'h8, v);
        chk("R7 clear", v, 8'h24);
        wr(4'h8, 8'h00);

        // R8 edge collides with a write of 0
        ext[2] = 1'b1;
        tick(2);
        wr(4'h8, 8'h00);
        rd(4'h8, v);
        chk("R8 collide", v, 8'h04);
        ext = 8'h00; tick(4);
        wr(4'h8, 8'h00);

        // R9 interrupt combine sweep
        wr(4'h8, 8'hA5);
        for (int g = 0; g < 2; g++) begin
            gie = g[0];
            for (int e = 0; e < 256; e++) begin
                wr(4'h6, 8'(e));
                chk("R9 irq", {7'b0, irq}, {7'b0, g[0] & (|(8'hA5 & 8'(e)))});
            end
        end
        gie = 1'b0;
        wr(4'h6, 8'h00);
        wr(4'h8, 8'h00);

        // R11 loopback writes
        wr(4'h1, 8'h01); tick(4);
        rd(4'h8, v);
        chk("R11 drive no oe", v, 8'h00);
        wr(4'h2, 8'h01); tick(4);
        rd(4'h8, v);
        chk("R11 oe rise", v, 8'h01);
        wr(4'h8, 8'h00);
        wr(4'h7, 8'h01);
        wr(4'h1, 8'h00); tick(4);
        rd(4'h8, v);
        chk("R11 drive fall", v, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule